// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Zero-Turnaround Bus

This block is a synthesizable behavioural model of a single-port synchronous memory. Every command, whether read, write or deselect, moves through one shared pipeline. Because of this, a read may follow a write, or a write may follow a read, on consecutive clock edges with no idle cycle in between. Read data appears one edge after the command edge. Write data is taken from the bus two edges after the command edge. The bus is released one edge after the command edge. So the controller never has to insert a turnaround cycle.

The data word is made of four 9-bit lanes, and each lane has its own write select. A burst unit lets one loaded address be followed by further accesses of the same type. These accesses walk the two low address bits in either linear or interleaved order. A clock enable freezes the whole block. A sleep input flushes the pipeline and ignores commands, and the stored contents are kept. The tri-state bus is modelled as three signals: a data input, a data output, and a drive enable.

Top module: `pipe_sram`

## Requirements
- R1: When `cen_n` is high and `sleep` is low, the clock edge has no effect. The pipeline, the burst state, the output register and `dq_oe` keep their values.
- R2: A command is accepted at an edge with `cen_n`=0 and `load_n`=0 only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. The address is captured at that edge. If `load_n`=0 and any enable is inactive, the edge is a deselect: nothing is read and nothing is written.
- R3: A read accepted at edge E (`we_n`=1) loads its word into the output register at edge E+1. That word is driven from E+1 until the next enabled edge, while `oe_n` is low.
- R4: A write accepted at edge E (`we_n`=0) releases the bus after E+1, whatever the state of `oe_n`. The write stores the `dq_in` value sampled at E+2.
- R5: A command may be accepted at every enabled edge. A read that directly follows a write to the same address returns the newly written data.
- R6: A deselect accepted at edge E leaves the bus undriven after E+1. A read accepted at E-1 is still driven between E and E+1.
- R7: `bw_n[i]`, sampled with the command, enables lane i, which is `dq[9*i+8:9*i]`. A lane with `bw_n[i]`=1 keeps its stored value.
- R8: `dq_oe` follows `oe_n` with no clock edge in between. `dq_oe` is 1 only when `oe_n`=0 and the pipeline holds valid read data.
- R9: An edge with `load_n`=1 continues the last loaded access and keeps its read or write type. The k-th continuation uses low address bits `(base+k) mod 4` when `ilv_mode` was 0 at load, and `base XOR k` when it was 1, wrapping after four. The upper bits stay fixed. If the last load edge was a deselect, each continuation is also a deselect.
- R10: At every edge with `sleep` high, commands are ignored and the pipeline is flushed to the deselected state, including any write in flight. The stored words are not changed.
- R11: If the data edge of a pending write is gated by `cen_n`=1, the write is held. It completes at the next enabled edge, using `dq_in` from that edge.
- R12: An active-low asynchronous `rst_n` clears the pipeline and the burst state, so the bus is undriven. The stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low pipeline reset |
| cen_n | input | 1 | Clock enable, active low |
| sel0_n | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | Low loads a new address, high continues the burst |
| we_n | input | 1 | Low selects write at a load edge |
| bw_n | input | 4 | Per-lane write selects, active low |
| ilv_mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Active-high low-activity request |
| addr | input | AW | Word address |
| dq_in | input | 36 | Bus value seen by the block |
| dq_out | output | 36 | Value the block drives when enabled |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A bad pipeline valid bit shows up on `dq_oe` one edge after the command that set it. It appears either as a drive during a write's data slot or as a missing drive for a read, so bus ownership is compared on every cycle. A wrong burst offset or lane mask leaves a bad word in storage that is visible only when that word is read back. The reads are therefore placed soon after each write pattern, and bursts are re-read in the other order. A missing forward from a write to a read of the same address corrupts `dq_out` in the very next data slot.

// File: rtl/psr_pkg.sv
package psr_pkg;

  // number of low address bits walked by a burst
  localparam int OFS_W = 2;

  // burst walk: linear adds the step count, interleaved xors it in
  function automatic logic [OFS_W-1:0] burst_offset(
    input logic [OFS_W-1:0] base,
    input logic [OFS_W-1:0] step,
    input logic             ilv
  );
    return ilv ? (base ^ step) : (base + step);
  endfunction

  // lane-wise merge: a lane takes fresh data when its select is low
  function automatic logic lane_pick(input logic sel_n);
    return ~sel_n;
  endfunction

endpackage

// File: rtl/psr_decode.sv
module psr_decode (
  input  logic cen_n,
  input  logic sel0_n,
  input  logic sel1,
  input  logic sel2_n,
  input  logic load_n,
  input  logic we_n,
  input  logic sleep,
  input  logic burst_live,
  input  logic burst_wr,
  output logic step,
  output logic flush,
  output logic do_load,
  output logic do_desel,
  output logic do_adv,
  output logic iss_valid,
  output logic iss_wr
);
  logic all_sel;

  always_comb begin
    all_sel   = ~sel0_n & sel1 & ~sel2_n;
    flush     = sleep;
    step      = ~cen_n & ~sleep;
    do_load   = ~load_n & all_sel;
    do_desel  = ~load_n & ~all_sel;
    do_adv    = load_n;
    iss_valid = do_load | (do_adv & burst_live);
    iss_wr    = do_load ? ~we_n : burst_wr;
  end
endmodule

// File: rtl/psr_burst.sv
module psr_burst
  import psr_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          flush,
  input  logic          do_load,
  input  logic          do_desel,
  input  logic          do_adv,
  input  logic          we_n,
  input  logic          ilv_mode,
  input  logic [AW-1:0] addr,
  output logic          live,
  output logic          wr,
  output logic [AW-1:0] adv_addr
);
  logic [AW-1:0]    base_q;
  logic [OFS_W-1:0] k_q;
  logic [OFS_W-1:0] k_next;
  logic             mode_q;

  always_comb begin
    k_next   = k_q + 1'b1;
    adv_addr = {base_q[AW-1:OFS_W], burst_offset(base_q[OFS_W-1:0], k_next, mode_q)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= 1'b0;
      wr     <= 1'b0;
      mode_q <= 1'b0;
      base_q <= '0;
      k_q    <= '0;
    end else if (flush) begin
      live <= 1'b0;
    end else if (step) begin
      if (do_load) begin
        live   <= 1'b1;
        wr     <= ~we_n;
        mode_q <= ilv_mode;
        base_q <= addr;
        k_q    <= '0;
      end else if (do_desel) begin
        live <= 1'b0;
      end else if (do_adv && live) begin
        k_q <= k_next;
      end
    end
  end
endmodule

// File: rtl/psr_store.sv
module psr_store #(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                          clk,
  input  logic [LANES-1:0]              lane_we,
  input  logic [AW-1:0]                 waddr,
  input  logic [LANES-1:0][LANE_W-1:0]  wdata,
  input  logic [AW-1:0]                 raddr,
  output logic [LANES-1:0][LANE_W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [LANES-1:0][LANE_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[waddr][g] <= wdata[g];
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/psr_pipe.sv
module psr_pipe
  import psr_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step,
  input  logic                          flush,
  input  logic                          iss_valid,
  input  logic                          iss_wr,
  input  logic [AW-1:0]                 iss_addr,
  input  logic [LANES-1:0]              iss_bw_n,
  input  logic [LANES-1:0][LANE_W-1:0]  bus_in,
  input  logic [LANES-1:0][LANE_W-1:0]  mem_rdata,
  output logic [AW-1:0]                 rd_addr,
  output logic [AW-1:0]                 wr_addr,
  output logic [LANES-1:0]              lane_we,
  output logic                          s1_valid,
  output logic                          s1_wr,
  output logic                          wr_pend,
  output logic                          wr_commit,
  output logic                          rd_load,
  output logic                          fwd_hit,
  output logic                          rd_valid,
  output logic [LANES-1:0][LANE_W-1:0]  rd_data
);
  logic [AW-1:0]                s1_addr;
  logic [LANES-1:0]             s1_bw_n;
  logic [AW-1:0]                s2_addr;
  logic [LANES-1:0]             s2_bw_n;
  logic [LANES-1:0][LANE_W-1:0] merged;

  assign rd_addr   = s1_addr;
  assign wr_addr   = s2_addr;
  assign wr_commit = step & wr_pend;
  assign rd_load   = step & s1_valid & ~s1_wr;
  assign fwd_hit   = wr_pend & (s2_addr == s1_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      lane_we[g] = wr_commit & lane_pick(s2_bw_n[g]);
      merged[g]  = (fwd_hit && lane_pick(s2_bw_n[g])) ? bus_in[g] : mem_rdata[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_bw_n  <= '1;
      wr_pend  <= 1'b0;
      s2_addr  <= '0;
      s2_bw_n  <= '1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (flush) begin
      s1_valid <= 1'b0;
      wr_pend  <= 1'b0;
      rd_valid <= 1'b0;
    end else if (step) begin
      s1_valid <= iss_valid;
      s1_wr    <= iss_wr;
      s1_addr  <= iss_addr;
      s1_bw_n  <= iss_bw_n;
      wr_pend  <= s1_valid & s1_wr;
      s2_addr  <= s1_addr;
      s2_bw_n  <= s1_bw_n;
      rd_valid <= s1_valid & ~s1_wr;
      if (s1_valid && !s1_wr) rd_data <= merged;
    end
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram #(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    load_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    ilv_mode,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DW = LANES * LANE_W;

  logic step, flush, do_load, do_desel, do_adv;
  logic iss_valid, iss_wr;
  logic burst_live, burst_wr;
  logic [AW-1:0] adv_addr, iss_addr, rd_addr, wr_addr;
  logic [LANES-1:0] lane_we;
  logic s1_valid, s1_wr, wr_pend, wr_commit, rd_load, fwd_hit, rd_valid;
  logic [LANES-1:0][LANE_W-1:0] bus_in, mem_rdata, rd_data;

  assign bus_in   = dq_in;
  assign iss_addr = do_load ? addr : adv_addr;

  psr_decode u_dec (
    .cen_n(cen_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .load_n(load_n), .we_n(we_n), .sleep(sleep),
    .burst_live(burst_live), .burst_wr(burst_wr),
    .step(step), .flush(flush), .do_load(do_load), .do_desel(do_desel),
    .do_adv(do_adv), .iss_valid(iss_valid), .iss_wr(iss_wr)
  );

  psr_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .step(step), .flush(flush),
    .do_load(do_load), .do_desel(do_desel), .do_adv(do_adv),
    .we_n(we_n), .ilv_mode(ilv_mode), .addr(addr),
    .live(burst_live), .wr(burst_wr), .adv_addr(adv_addr)
  );

  psr_pipe #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .step(step), .flush(flush),
    .iss_valid(iss_valid), .iss_wr(iss_wr), .iss_addr(iss_addr), .iss_bw_n(bw_n),
    .bus_in(bus_in), .mem_rdata(mem_rdata),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .lane_we(lane_we),
    .s1_valid(s1_valid), .s1_wr(s1_wr), .wr_pend(wr_pend), .wr_commit(wr_commit),
    .rd_load(rd_load), .fwd_hit(fwd_hit), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  psr_store #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_store (
    .clk(clk), .lane_we(lane_we), .waddr(wr_addr), .wdata(bus_in),
    .raddr(rd_addr), .rdata(mem_rdata)
  );

  assign dq_out = DW'(rd_data);
  assign dq_oe  = rd_valid & ~oe_n;
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cen_n,
  input logic          sleep,
  input logic          oe_n,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic          rd_valid,
  input logic          s1_valid,
  input logic          s1_wr,
  input logic          wr_pend,
  input logic          wr_commit
);
  a_r1_gated_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && !sleep) |=> ($stable(rd_valid) && $stable(dq_out)));

  a_r3_read_fills_output: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !sleep && s1_valid && !s1_wr) |=> rd_valid);

  a_r4_write_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !sleep && s1_valid && s1_wr) |=> !dq_oe);

  a_r6_deselect_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !sleep && !s1_valid) |=> !dq_oe);

  a_r8_oe_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  a_r10_sleep_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!rd_valid && !wr_commit));

  a_r11_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && !sleep && wr_pend) |=> wr_pend);
endmodule

bind pipe_sram psr_checker #(.DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sleep(sleep), .oe_n(oe_n),
  .dq_oe(dq_oe), .dq_out(dq_out), .rd_valid(rd_valid),
  .s1_valid(s1_valid), .s1_wr(s1_wr), .wr_pend(wr_pend), .wr_commit(wr_commit)
);

// File: tb/pipe_sram_tb.sv
module pipe_sram_tb;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cen_n = 1'b0, sel0_n = 1'b1, sel1 = 1'b1, sel2_n = 1'b0;
  logic load_n = 1'b0, we_n = 1'b1, ilv_mode = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  pipe_sram #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .load_n(load_n), .we_n(we_n), .bw_n(bw_n),
    .ilv_mode(ilv_mode), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R12";

  // behavioural reference
  logic [DW-1:0] ref_mem [64];
  bit m_outv = 0, p1v = 0, p1w = 0, p2v = 0, b_act = 0, b_we = 0, b_mode = 0;
  logic [DW-1:0] m_outd = '0;
  int p1a = 0, p2a = 0, b_base = 0, b_k = 0;
  logic [3:0] p1bw = 4'hF, p2bw = 4'hF;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || sleep) begin
      m_outv = 0; p1v = 0; p2v = 0; b_act = 0;
    end else if (!cen_n) begin
      bit iv, iw;
      int ia;
      if (p2v)
        for (int i = 0; i < 4; i++)
          if (!p2bw[i]) ref_mem[p2a][i*9 +: 9] = dq_in[i*9 +: 9];
      m_outv = p1v && !p1w;
      if (m_outv) m_outd = ref_mem[p1a];
      p2v = p1v && p1w; p2a = p1a; p2bw = p1bw;
      iv = 0; iw = 0; ia = 0;
      if (!load_n) begin
        if (!sel0_n && sel1 && !sel2_n) begin
          iv = 1; iw = !we_n; ia = addr;
          b_act = 1; b_we = !we_n; b_base = addr; b_k = 0; b_mode = ilv_mode;
        end else b_act = 0;
      end else if (b_act) begin
        int lo;
        b_k = (b_k + 1) % 4;
        lo = b_mode ? ((b_base % 4) ^ b_k) : (((b_base % 4) + b_k) % 4);
        iv = 1; iw = b_we; ia = (b_base / 4) * 4 + lo;
      end
      p1v = iv; p1w = iw; p1a = ia; p1bw = bw_n;
    end
  end

  // bus ownership and data compared every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_tag, DW'(dq_oe), DW'(m_outv && !oe_n), "drive");
      if (m_outv && !oe_n) chk(cur_tag, dq_out, m_outd, "data");
    end
  end

  function automatic logic [DW-1:0] pat(input int n);
    logic [DW-1:0] v;
    for (int i = 0; i < 4; i++) v[i*9 +: 9] = 9'(n * 29 + i * 83 + 5);
    return v;
  endfunction

  task automatic cmd(input logic c, input logic s0, input logic s1v, input logic s2,
                     input logic ld, input logic we, input logic [3:0] bw, input int a);
    @(posedge clk); #2;
    cen_n = c; sel0_n = s0; sel1 = s1v; sel2_n = s2; load_n = ld; we_n = we;
    bw_n = bw; addr = AW'(a); dq_in = pat(cyc);
  endtask

  task automatic wr(input int a, input logic [3:0] bw); cmd(0, 0, 1, 0, 0, 0, bw, a); endtask
  task automatic rd(input int a);  cmd(0, 0, 1, 0, 0, 1, 4'hF, a); endtask
  task automatic nop();            cmd(0, 1, 1, 0, 0, 1, 4'hF, 0); endtask
  task automatic adv();            cmd(0, 0, 1, 0, 1, 1, 4'h0, 0); endtask
  task automatic hold();           cmd(1, 0, 1, 0, 0, 1, 4'hF, 0); endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1 chk("R12", DW'(dq_oe), '0, "reset drive");
    nop(); nop();
    // preload all words so storage starts defined in the comparison
    cur_tag = "R4";
    for (int i = 0; i < 64; i++) wr(i, 4'h0);
    nop(); nop();
    cur_tag = "R3";
    for (int i = 0; i < 8; i++) rd(i);
    nop(); nop();
    cur_tag = "R5";
    wr(10, 0); rd(10); wr(11, 0); rd(11); rd(10); wr(10, 0); wr(12, 0); rd(12); rd(10);
    nop(); nop();
    cur_tag = "R7";
    wr(20, 4'b1110); wr(20, 4'b0101); rd(20); wr(21, 4'b0111); wr(22, 4'b1011); rd(21); rd(22);
    nop(); nop();
    cur_tag = "R6";
    rd(1); cmd(0, 1, 1, 0, 0, 1, 4'hF, 2); rd(2); cmd(0, 0, 0, 0, 0, 1, 4'hF, 3);
    rd(3); cmd(0, 0, 1, 1, 0, 1, 4'hF, 4); rd(4); nop();
    cur_tag = "R2";
    cmd(0, 0, 0, 0, 0, 0, 4'h0, 5); cmd(0, 1, 1, 0, 0, 0, 4'h0, 6); nop(); nop();
    rd(5); rd(6); nop(); nop();
    cur_tag = "R9";
    ilv_mode = 0; wr(33, 0); adv(); adv(); adv(); adv();
    ilv_mode = 1; rd(33); adv(); adv(); adv();
    wr(46, 0); adv(); adv(); adv();
    ilv_mode = 0; rd(44); adv(); adv(); adv();
    rd(46); rd(47); rd(45); rd(44);
    nop(); adv(); adv(); nop(); nop();
    cur_tag = "R11";
    wr(50, 0); nop(); hold(); hold(); nop(); rd(50); nop(); nop();
    cur_tag = "R1";
    rd(50); rd(0); hold(); hold(); hold(); nop(); hold(); nop(); nop();
    cur_tag = "R8";
    rd(3); nop();
    @(posedge clk); #1 oe_n = 1'b1;
    #1 chk("R8", DW'(dq_oe), '0, "oe high drive");
    oe_n = 1'b0;
    #1 chk("R8", DW'(dq_oe), DW'(1), "oe low drive");
    chk("R8", dq_out, ref_mem[3], "oe low data");
    nop(); nop();
    cur_tag = "R10";
    rd(7); sleep = 1'b1; wr(0, 0); rd(0); wr(1, 0); adv();
    sleep = 1'b0; nop(); rd(0); rd(1); rd(7); nop(); nop();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule